// File: doc/BRIEF.md
# Prescaled Input Capture Timer

This block is a free-running down counter with a programmable clock divider in front of it. It also takes a snapshot of the count when an external signal changes. The external signal is brought into the clock domain through a short synchroniser. On the chosen transition, the count value at that moment is latched into a capture register that software can only read. The timer raises two status flags: one when the counter wraps below zero and one when a snapshot is taken. Each flag can drive the shared interrupt line through its own enable.

Software sets up the block through a small word-wide register bus. It picks the divide ratio, loads the counter, chooses the active input edge, and starts or halts the timer. Elapsed time between input events follows from the difference of successive snapshots. When interrupts are not in use, software halts the timer and then polls the flags. The flags stay set until software explicitly writes zero to them.

Top module: `capt_timer`

## Requirements
- R1: After a synchronous reset, every register reads zero (control, status, prescaler, count, capture) and `irq` is low.
- R2: While running, the count decreases by one every P+1 clock cycles, where P is the 8-bit prescaler value at address 2. Writing address 2 also reloads the divider phase, so the first decrement after starting follows P+1 cycles after the run bit is set.
- R3: A decrement from 0x0000 wraps the count to 0xFFFF and sets the underflow flag (status bit 1).
- R4: Control bit 0 (address 0) is the run bit. While it is 0, the count and the divider hold their values and input transitions cause no capture.
- R5: An input change applied between two clock edges is synchronised by two flops and detected as an edge. The capture register (address 4) then receives the count held just before the third rising clock edge after the change.
- R6: Control bit 1 selects the active edge: 0 means low-to-high and 1 means high-to-low. A transition of the other polarity neither changes the capture register nor sets the capture flag.
- R7: Each capture sets the capture flag (status bit 0, address 1).
- R8: A status flag clears only when software writes 0 to its bit at address 1. Writing 1 leaves the flag unchanged, and flags remain set while the timer is halted.
- R9: If a capture and an underflow happen on the same clock edge, both flags are set. A set also wins over a clear written on the same edge.
- R10: The capture register is read-only, and writes to address 4 have no effect.
- R11: `irq` is high exactly when (capture flag AND control bit 2) OR (underflow flag AND control bit 3).
- R12: `bus_rdata` presents the register selected by `bus_addr` one clock after the address is applied. The count at address 3 can be written and read back, and unused addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_in | input | 1 | Asynchronous capture input |
| bus_addr | input | 3 | Register select |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
Register writes take effect on the edge that samples the strobe. Read data and `irq` follow one edge later. A capture lands on the third edge after the input moves. The bench derives each expected count from the number of divider periods that elapse between the run-set edge and the run-clear edge. It samples every result on the falling clock edge after the edge where the value is due. A sweep over divide ratios and run lengths from a small starting count covers divided counting and wrap. Capture values are computed from the edge index of the input change.

// File: rtl/capt_pkg.sv
package capt_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL  = 3'd0,
    SEL_STAT  = 3'd1,
    SEL_DIV   = 3'd2,
    SEL_COUNT = 3'd3,
    SEL_SNAP  = 3'd4
  } reg_sel_e;

  localparam int CTL_RUN   = 0;
  localparam int CTL_FALL  = 1;
  localparam int CTL_CIE   = 2;
  localparam int CTL_UIE   = 3;
  localparam int ST_CAP    = 0;
  localparam int ST_UNF    = 1;
endpackage

// File: rtl/capt_edge_det.sv
module capt_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic fall_sel,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              rise, fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise   = sync_q[STAGES-1] & ~prev_q;
  assign fall   = ~sync_q[STAGES-1] & prev_q;
  assign edge_o = fall_sel ? fall : rise;

  // R5
  rise_single_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/capt_prescale.sv
module capt_prescale #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload,
  output logic         tick
);
  logic [W-1:0] phase_q;

  assign tick = en && (phase_q == '0);

  always_ff @(posedge clk) begin
    if (rst)          phase_q <= '0;
    else if (load)    phase_q <= load_val;
    else if (en)      phase_q <= (phase_q == '0) ? reload : phase_q - 1'b1;
  end

  // R2
  div_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !load) |=> (phase_q == $past(reload)));
  // R4
  div_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> $stable(phase_q));
endmodule

// File: rtl/capt_timer.sv
module capt_timer
  import capt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic              run_q, fall_q, cie_q, uie_q;
  logic [DIV_W-1:0]  div_q;
  logic [CNT_W-1:0]  cnt_q, snap_q, rdata_q;
  logic              cap_pend_q, unf_pend_q;
  logic              wr_ctrl, wr_stat, wr_div, wr_cnt;
  logic              tick, edge_hit, cap_evt, unf_evt;

  assign wr_ctrl = bus_wr && (bus_addr == SEL_CTRL);
  assign wr_stat = bus_wr && (bus_addr == SEL_STAT);
  assign wr_div  = bus_wr && (bus_addr == SEL_DIV);
  assign wr_cnt  = bus_wr && (bus_addr == SEL_COUNT);

  capt_edge_det #(.STAGES(SYNC_N)) u_edge (
    .clk(clk), .rst(rst), .din(cap_in), .fall_sel(fall_q), .edge_o(edge_hit)
  );

  capt_prescale #(.W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .en(run_q), .load(wr_div),
    .load_val(bus_wdata[DIV_W-1:0]), .reload(div_q), .tick(tick)
  );

  assign cap_evt = run_q && edge_hit;
  assign unf_evt = tick && !wr_cnt && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0; fall_q <= 1'b0; cie_q <= 1'b0; uie_q <= 1'b0;
      div_q <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q  <= bus_wdata[CTL_RUN];
        fall_q <= bus_wdata[CTL_FALL];
        cie_q  <= bus_wdata[CTL_CIE];
        uie_q  <= bus_wdata[CTL_UIE];
      end
      if (wr_div) div_q <= bus_wdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (wr_cnt) cnt_q <= bus_wdata;
    else if (tick)   cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)          snap_q <= '0;
    else if (cap_evt) snap_q <= cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_pend_q <= 1'b0;
      unf_pend_q <= 1'b0;
    end else begin
      cap_pend_q <= cap_evt | (cap_pend_q & ~(wr_stat & ~bus_wdata[ST_CAP]));
      unf_pend_q <= unf_evt | (unf_pend_q & ~(wr_stat & ~bus_wdata[ST_UNF]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else begin
      rdata_q <= '0;
      case (bus_addr)
        SEL_CTRL: begin
          rdata_q[CTL_RUN]  <= run_q;
          rdata_q[CTL_FALL] <= fall_q;
          rdata_q[CTL_CIE]  <= cie_q;
          rdata_q[CTL_UIE]  <= uie_q;
        end
        SEL_STAT: begin
          rdata_q[ST_CAP] <= cap_pend_q;
          rdata_q[ST_UNF] <= unf_pend_q;
        end
        SEL_DIV:   rdata_q[DIV_W-1:0] <= div_q;
        SEL_COUNT: rdata_q <= cnt_q;
        SEL_SNAP:  rdata_q <= snap_q;
        default:   rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign irq = (cap_pend_q & cie_q) | (unf_pend_q & uie_q);

  // R3
  wrap_to_max_chk: assert property (@(posedge clk) disable iff (rst)
    unf_evt |=> (cnt_q == CNT_MAX) && unf_pend_q);
  // R4
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !wr_cnt) |=> $stable(cnt_q));
  // R7
  cap_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> cap_pend_q && (snap_q == $past(cnt_q)));
  // R8
  cap_clear_only_sw_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cap_pend_q) |-> $past(wr_stat && !bus_wdata[ST_CAP]));
  // R8
  unf_clear_only_sw_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(unf_pend_q) |-> $past(wr_stat && !bus_wdata[ST_UNF]));
  // R10
  snap_readonly_chk: assert property (@(posedge clk) disable iff (rst)
    !cap_evt |=> $stable(snap_q));
endmodule

// File: tb/sim_capt_timer.sv
module sim_capt_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cap_in = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;
  int checks = 0, errors = 0;
  logic [15:0] rv;

  capt_timer u0 (.clk(clk), .rst(rst), .cap_in(cap_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    @(posedge clk); @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(a[2:0], rv); chk("R1 reset reg", rv, 16'h0);
    end
    chk("R1 irq", {15'd0, irq}, 16'h0);

    // R12 count write/read and unused address
    wr(3'd3, 16'hBEEF); rd(3'd3, rv); chk("R12 count rw", rv, 16'hBEEF);
    rd(3'd6, rv); chk("R12 unused", rv, 16'h0);

    // R2 R3 sweep over prescale and run length
    for (int p = 0; p < 6; p++) begin
      for (int w = 0; w < 10; w++) begin
        int ticks;
        logic [15:0] exp;
        wr(3'd1, 16'h0);
        wr(3'd2, p[15:0]);
        wr(3'd3, 16'd3);
        wr(3'd0, 16'h1);
        idle(w);
        wr(3'd0, 16'h0);
        ticks = (w + 1) / (p + 1);
        exp = 16'(3 - ticks);
        rd(3'd3, rv); chk("R2 R3 count", rv, exp);
        rd(3'd1, rv); chk("R3 underflow flag", rv, (ticks > 3) ? 16'h2 : 16'h0);
      end
    end

    // R4 halted: no count change, no capture
    wr(3'd1, 16'h0); wr(3'd3, 16'd77);
    cap_in = 1'b1; idle(6); cap_in = 1'b0; idle(6);
    rd(3'd3, rv); chk("R4 hold count", rv, 16'd77);
    rd(3'd1, rv); chk("R4 no capture", rv, 16'h0);

    // R5 R7 R11 rising capture
    wr(3'd2, 16'h0); wr(3'd3, 16'd1000);
    wr(3'd0, 16'h5);
    idle(4); cap_in = 1'b1; idle(6);
    chk("R11 irq capture", {15'd0, irq}, 16'h1);
    wr(3'd0, 16'h0);
    rd(3'd4, rv); chk("R5 capture value", rv, 16'd994);
    rd(3'd1, rv); chk("R7 capture flag", rv, 16'h1);
    chk("R11 irq after disable", {15'd0, irq}, 16'h0);

    // R6 opposite edge ignored
    wr(3'd1, 16'h0); wr(3'd3, 16'd500); wr(3'd0, 16'h1);
    idle(2); cap_in = 1'b0; idle(6); wr(3'd0, 16'h0);
    rd(3'd1, rv); chk("R6 no flag", rv, 16'h0);
    rd(3'd4, rv); chk("R6 capture kept", rv, 16'd994);

    // R6 falling mode
    cap_in = 1'b1; idle(5);
    wr(3'd3, 16'd2000); wr(3'd0, 16'h3);
    idle(2); cap_in = 1'b0; idle(6); wr(3'd0, 16'h0);
    rd(3'd4, rv); chk("R6 falling capture", rv, 16'd1996);

    // R10 read-only capture
    wr(3'd4, 16'h1234); rd(3'd4, rv); chk("R10 write ignored", rv, 16'd1996);

    // R8 clear semantics
    wr(3'd3, 16'd0); wr(3'd0, 16'h1); wr(3'd0, 16'h0);
    rd(3'd1, rv); chk("R8 both held", rv, 16'h3);
    wr(3'd0, 16'h8);
    chk("R11 irq underflow", {15'd0, irq}, 16'h1);
    wr(3'd1, 16'h2); rd(3'd1, rv); chk("R8 clear cap only", rv, 16'h2);
    wr(3'd1, 16'h3); rd(3'd1, rv); chk("R8 write one keeps", rv, 16'h2);
    wr(3'd1, 16'h0); rd(3'd1, rv); chk("R8 clear all", rv, 16'h0);
    chk("R11 irq low", {15'd0, irq}, 16'h0);

    // R9 simultaneous capture and underflow
    wr(3'd0, 16'h0); cap_in = 1'b0; idle(5);
    wr(3'd3, 16'd5); wr(3'd0, 16'h1);
    idle(3); cap_in = 1'b1; idle(6); wr(3'd0, 16'h0);
    rd(3'd1, rv); chk("R9 both flags", rv, 16'h3);
    rd(3'd4, rv); chk("R9 captured zero", rv, 16'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule